// File: doc/BRIEF.md
# Machine-Level CSR and Trap Sequencer

This block holds the machine-mode control and status registers of a single-cycle RV32 core and decides when execution must leave the normal instruction stream. It executes the six Zicsr read-modify-write forms. The core resolves the register or immediate operand before it reaches the block and also reports whether the source field was zero. The block watches timer and software interrupt lines from the local interruptor and takes an interrupt at an instruction boundary when the global and per-source enables allow it. The trap return instruction sends the core back to the saved PC.

The core pulses `retire_i` once for each instruction. In that cycle it presents the PC of the instruction, together with the CSR access or trap-return request if the instruction has one. Read data, the redirect flag and the redirect target are registered and appear one clock later. If an interrupt is taken in a cycle, the instruction in that cycle is abandoned. Its CSR write is dropped, its PC becomes the saved return address, and it runs again after the handler returns.

Top module: `mcsr_trap_unit`

## Requirements
- R1: After synchronous reset, the status, enable, vector, return-address and cause registers all read 0, and `redirect_o` and `csr_rdata_o` are 0.
- R2: For operation code 1 (write), the cycle after a strobed access `csr_rdata_o` holds the register's old value, and the register then holds the operand after its field mask.
- R3: Operation code 2 ORs the operand into the register, and operation code 3 clears the operand's set bits. Both return the old value.
- R4: When `csr_src_zero_i` is 1, operation codes 2 and 3 leave the register unchanged, whatever the operand is, and still return the old value.
- R5: Addresses and field masks are as follows. Status 0x300 keeps only bit 3 (global enable) and bit 7 (previous enable). Enable 0x304 keeps only bit 7 (timer) and bit 3 (software). Vector 0x305 and return address 0x341 force bits 1:0 to 0. Cause 0x342 keeps all 32 bits. Pending 0x344 reads bit 7 = timer line and bit 3 = software line, and writes to it are ignored.
- R6: An interrupt is taken only in a strobed cycle where status bit 3 is 1 and a raised line has its enable bit set.
- R7: On interrupt entry, the return address takes `pc_i`, status bit 7 takes the old bit 3, and bit 3 is cleared. The next cycle, `redirect_o` is 1 with `redirect_pc_o` equal to the vector with bits 1:0 cleared.
- R8: The cause register is written with bit 31 set and code 7 for the timer or code 3 for software. The timer wins when both are pending and enabled.
- R9: A taken interrupt overrides a CSR write or trap return in the same cycle. No software write lands, and the redirect goes to the vector.
- R10: A strobed trap return, with no interrupt taken, copies status bit 7 into bit 3, sets bit 7 to 1, and redirects the next cycle to the return address.
- R11: Without `retire_i`, no register changes and no redirect occurs. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Instruction boundary strobe |
| csr_en_i | input | 1 | Instruction in this cycle is a CSR access |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 1 write, 2 set, 3 clear, 0 none |
| csr_src_zero_i | input | 1 | Source register or immediate field is zero |
| csr_wdata_i | input | 32 | Resolved operand |
| mret_i | input | 1 | Instruction in this cycle is a trap return |
| pc_i | input | 32 | PC of the instruction at the boundary |
| irq_timer_i | input | 1 | Timer interrupt line |
| irq_soft_i | input | 1 | Software interrupt line |
| csr_rdata_o | output | 32 | Old value of the accessed CSR, registered |
| redirect_o | output | 1 | Fetch must move to `redirect_pc_o` |
| redirect_pc_o | output | 32 | Redirect target |

## Verification
The hardest situation to reach is an interrupt that arrives in the same boundary cycle as an instruction that writes the cause register, or as a trap return. Both interrupt lines must be raised while both enable levels are armed. The stimulus reaches this point by first programming the vector, the enable register and the status register through ordinary CSR writes. It then drives a cause write and, in a later step, a trap return in the very cycle the lines are high. Read-backs then show that the trap values won and that the return address is the abandoned instruction's PC.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam int XLEN   = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_STATUS = 12'h300;
  localparam logic [ADDR_W-1:0] A_IEN    = 12'h304;
  localparam logic [ADDR_W-1:0] A_VEC    = 12'h305;
  localparam logic [ADDR_W-1:0] A_EPC    = 12'h341;
  localparam logic [ADDR_W-1:0] A_CAUSE  = 12'h342;
  localparam logic [ADDR_W-1:0] A_PEND   = 12'h344;

  // bit positions used by status, enable and pending registers
  localparam int GIE_BIT  = 3;
  localparam int PGIE_BIT = 7;
  localparam int TMR_BIT  = 7;
  localparam int SFT_BIT  = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

endpackage

// File: rtl/mcsr_irq_arb.sv
module mcsr_irq_arb #(
  parameter int XLEN       = 32,
  parameter int TIMER_CODE = 7,
  parameter int SOFT_CODE  = 3
) (
  input  logic            strobe,
  input  logic            gie,
  input  logic            line_tmr,
  input  logic            line_sft,
  input  logic            en_tmr,
  input  logic            en_sft,
  output logic            take,
  output logic [XLEN-1:0] cause
);
  localparam logic [XLEN-1:0] INT_FLAG = {1'b1, {(XLEN-1){1'b0}}};

  logic hit_tmr, hit_sft;

  always_comb begin
    hit_tmr = line_tmr & en_tmr;
    hit_sft = line_sft & en_sft;
    take    = strobe & gie & (hit_tmr | hit_sft);
    // R8: timer outranks software
    if (hit_tmr) cause = INT_FLAG | XLEN'(TIMER_CODE);
    else         cause = INT_FLAG | XLEN'(SOFT_CODE);
  end
endmodule

// File: rtl/mcsr_wval.sv
module mcsr_wval
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op,
  input  logic            src_zero,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] operand,
  output logic            wr_req,
  output logic [XLEN-1:0] new_val
);
  always_comb begin
    wr_req  = 1'b0;
    new_val = old_val;
    unique case (op)
      OP_WRITE: begin
        wr_req  = 1'b1;
        new_val = operand;
      end
      OP_SET: begin
        wr_req  = ~src_zero;  // R4
        new_val = old_val | operand;
      end
      OP_CLEAR: begin
        wr_req  = ~src_zero;  // R4
        new_val = old_val & ~operand;
      end
      default: begin
        wr_req  = 1'b0;
        new_val = old_val;
      end
    endcase
  end
endmodule

// File: rtl/mcsr_regs.sv
module mcsr_regs
  import mcsr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [XLEN-1:0]   sw_val,
  input  logic              trap_take,
  input  logic [XLEN-1:0]   trap_cause,
  input  logic [XLEN-1:0]   trap_epc,
  input  logic              ret_do,
  output logic              st_gie,
  output logic              st_pgie,
  output logic              ie_tmr,
  output logic              ie_sft,
  output logic [XLEN-1:0]   vec_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   cause_q
);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_gie  <= 1'b0;
      st_pgie <= 1'b0;
      ie_tmr  <= 1'b0;
      ie_sft  <= 1'b0;
      vec_q   <= '0;
      epc_q   <= '0;
      cause_q <= '0;
    end else if (trap_take) begin
      // R9: trap entry updates atomically; any software write is dropped
      epc_q   <= trap_epc & ALIGN_MASK;
      cause_q <= trap_cause;
      st_pgie <= st_gie;
      st_gie  <= 1'b0;
    end else begin
      if (ret_do) begin
        st_gie  <= st_pgie;
        st_pgie <= 1'b1;
      end
      if (sw_we) begin
        unique case (sw_addr)
          A_STATUS: begin
            st_gie  <= sw_val[GIE_BIT];
            st_pgie <= sw_val[PGIE_BIT];
          end
          A_IEN: begin
            ie_tmr <= sw_val[TMR_BIT];
            ie_sft <= sw_val[SFT_BIT];
          end
          A_VEC:   vec_q   <= sw_val & ALIGN_MASK;
          A_EPC:   epc_q   <= sw_val & ALIGN_MASK;
          A_CAUSE: cause_q <= sw_val;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
  import mcsr_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ADDR_W     = 12,
  parameter int TIMER_CODE = 7,
  parameter int SOFT_CODE  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_i,
  input  logic              csr_en_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [1:0]        csr_op_i,
  input  logic              csr_src_zero_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic              mret_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              irq_timer_i,
  input  logic              irq_soft_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o
);
  logic            st_gie, st_pgie, ie_tmr, ie_sft;
  logic [XLEN-1:0] vec_q, epc_q, cause_q;
  logic            trap_take;
  logic [XLEN-1:0] trap_cause;
  logic            is_csr, ret_do, wr_req, sw_we;
  logic [XLEN-1:0] old_val, new_val;
  csr_op_e         op;

  assign op = csr_op_e'(csr_op_i);

  // R6, R8: interrupt qualification and priority
  mcsr_irq_arb #(
    .XLEN(XLEN), .TIMER_CODE(TIMER_CODE), .SOFT_CODE(SOFT_CODE)
  ) u_arb (
    .strobe  (retire_i),
    .gie     (st_gie),
    .line_tmr(irq_timer_i),
    .line_sft(irq_soft_i),
    .en_tmr  (ie_tmr),
    .en_sft  (ie_sft),
    .take    (trap_take),
    .cause   (trap_cause)
  );

  // R5, R11: read multiplexer with field views
  always_comb begin
    old_val = '0;
    unique case (csr_addr_i)
      A_STATUS: begin
        old_val[GIE_BIT]  = st_gie;
        old_val[PGIE_BIT] = st_pgie;
      end
      A_IEN: begin
        old_val[TMR_BIT] = ie_tmr;
        old_val[SFT_BIT] = ie_sft;
      end
      A_VEC:   old_val = vec_q;
      A_EPC:   old_val = epc_q;
      A_CAUSE: old_val = cause_q;
      A_PEND: begin
        old_val[TMR_BIT] = irq_timer_i;
        old_val[SFT_BIT] = irq_soft_i;
      end
      default: old_val = '0;
    endcase
  end

  mcsr_wval #(.XLEN(XLEN)) u_wval (
    .op      (op),
    .src_zero(csr_src_zero_i),
    .old_val (old_val),
    .operand (csr_wdata_i),
    .wr_req  (wr_req),
    .new_val (new_val)
  );

  assign is_csr = retire_i & csr_en_i & ~mret_i;
  assign sw_we  = is_csr & wr_req;            // R11: gated by strobe
  assign ret_do = retire_i & mret_i & ~trap_take;

  mcsr_regs #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (sw_we),
    .sw_addr   (csr_addr_i),
    .sw_val    (new_val),
    .trap_take (trap_take),
    .trap_cause(trap_cause),
    .trap_epc  (pc_i),
    .ret_do    (ret_do),
    .st_gie    (st_gie),
    .st_pgie   (st_pgie),
    .ie_tmr    (ie_tmr),
    .ie_sft    (ie_sft),
    .vec_q     (vec_q),
    .epc_q     (epc_q),
    .cause_q   (cause_q)
  );

  // registered outputs (R2, R7, R10)
  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata_o   <= '0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      if (is_csr) csr_rdata_o <= old_val;
      redirect_o <= trap_take | ret_do;
      if (trap_take)   redirect_pc_o <= {vec_q[XLEN-1:2], 2'b00};
      else if (ret_do) redirect_pc_o <= epc_q;
    end
  end
endmodule

// File: rtl/mcsr_trap_unit_chk.sv
module mcsr_trap_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            retire_i,
  input logic            mret_i,
  input logic            irq_timer_i,
  input logic            irq_soft_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            trap_take,
  input logic            st_gie,
  input logic            st_pgie
);
  p_take_needs_line_r6: assert property (@(posedge clk) disable iff (rst)
    trap_take |-> (retire_i && (irq_timer_i || irq_soft_i)));

  p_entry_clears_gie_r7: assert property (@(posedge clk) disable iff (rst)
    trap_take |=> (!st_gie && st_pgie == $past(st_gie)));

  p_ret_restores_r10: assert property (@(posedge clk) disable iff (rst)
    (retire_i && mret_i && !trap_take) |=> (st_gie == $past(st_pgie) && st_pgie));

  p_no_strobe_no_redirect_r11: assert property (@(posedge clk) disable iff (rst)
    !retire_i |=> !redirect_o);

  p_target_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (redirect_pc_o[1:0] == 2'b00));
endmodule

bind mcsr_trap_unit mcsr_trap_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .retire_i     (retire_i),
  .mret_i       (mret_i),
  .irq_timer_i  (irq_timer_i),
  .irq_soft_i   (irq_soft_i),
  .redirect_o   (redirect_o),
  .redirect_pc_o(redirect_pc_o),
  .trap_take    (trap_take),
  .st_gie       (st_gie),
  .st_pgie      (st_pgie)
);

// File: tb/tb_mcsr_trap_unit.sv
module tb_mcsr_trap_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        retire_i, csr_en_i, csr_src_zero_i, mret_i, irq_timer_i, irq_soft_i;
  logic [11:0] csr_addr_i;
  logic [1:0]  csr_op_i;
  logic [31:0] csr_wdata_i, pc_i, csr_rdata_o, redirect_pc_o;
  logic        redirect_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcsr_trap_unit dut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        ret;
    logic        en;
    logic [11:0] addr;
    logic [1:0]  op;
    logic        z;
    logic [31:0] wd;
    logic        mr;
    logic [31:0] pc;
    logic        tmr;
    logic        sw;
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic        exp_rv;
    logic [31:0] exp_rpc;
  } vec_t;

  localparam int NV = 38;
  // op: 1 write, 2 set, 3 clear; a read is a set with zero source
  localparam vec_t TBL [0:NV-1] = '{
    '{4'd1, 1,1,12'h300,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R1
    '{4'd1, 1,1,12'h305,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R1
    '{4'd2, 1,1,12'h305,2'd1,0,32'h1003,    0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R2
    '{4'd5, 1,1,12'h305,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h1000,    0,32'h0},    // R5
    '{4'd5, 1,1,12'h304,2'd1,0,32'hFFFFFFFF,0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R5
    '{4'd5, 1,1,12'h304,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h88,      0,32'h0},    // R5
    '{4'd2, 1,1,12'h300,2'd1,0,32'hFFFFFFFF,0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R2
    '{4'd5, 1,1,12'h300,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h88,      0,32'h0},    // R5
    '{4'd3, 1,1,12'h300,2'd3,0,32'h8,       0,32'h0,   0,0, 1,32'h88,      0,32'h0},    // R3
    '{4'd3, 1,1,12'h300,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h80,      0,32'h0},    // R3
    '{4'd3, 1,1,12'h342,2'd2,0,32'h5,       0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R3
    '{4'd4, 1,1,12'h342,2'd3,1,32'hF,       0,32'h0,   0,0, 1,32'h5,       0,32'h0},    // R4
    '{4'd4, 1,1,12'h342,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h5,       0,32'h0},    // R4
    '{4'd5, 1,1,12'h344,2'd2,1,32'h0,       0,32'h0,   1,1, 1,32'h88,      0,32'h0},    // R5 R6
    '{4'd5, 1,1,12'h344,2'd1,0,32'hFFFFFFFF,0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R5
    '{4'd5, 1,1,12'h344,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R5
    '{4'd3, 1,1,12'h300,2'd2,0,32'h8,       0,32'h0,   0,0, 1,32'h80,      0,32'h0},    // R3
    '{4'd6, 0,0,12'h0,  2'd0,0,32'h0,       0,32'h0,   1,0, 0,32'h0,       0,32'h0},    // R6
    '{4'd9, 1,1,12'h342,2'd1,0,32'h1234,    0,32'h200, 1,1, 0,32'h0,       1,32'h1000}, // R9 R8
    '{4'd7, 1,1,12'h342,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h80000007,0,32'h0},    // R7 R8
    '{4'd7, 1,1,12'h341,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h200,     0,32'h0},    // R7
    '{4'd7, 1,1,12'h300,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h80,      0,32'h0},    // R7
    '{4'd6, 1,1,12'h300,2'd2,1,32'h0,       0,32'h0,   0,1, 1,32'h80,      0,32'h0},    // R6
    '{4'd10,1,0,12'h0,  2'd0,0,32'h0,       1,32'h1000,0,0, 0,32'h0,       1,32'h200},  // R10
    '{4'd10,1,1,12'h300,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h88,      0,32'h0},    // R10
    '{4'd7, 1,0,12'h0,  2'd0,0,32'h0,       0,32'h300, 0,1, 0,32'h0,       1,32'h1000}, // R7
    '{4'd8, 1,1,12'h342,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h80000003,0,32'h0},    // R8
    '{4'd5, 1,1,12'h304,2'd1,0,32'h80,      0,32'h0,   0,0, 1,32'h88,      0,32'h0},    // R5
    '{4'd10,1,0,12'h0,  2'd0,0,32'h0,       1,32'h1004,0,0, 0,32'h0,       1,32'h300},  // R10
    '{4'd6, 1,0,12'h0,  2'd0,0,32'h0,       0,32'h500, 0,1, 0,32'h0,       0,32'h0},    // R6
    '{4'd9, 1,0,12'h0,  2'd0,0,32'h0,       1,32'h400, 1,0, 0,32'h0,       1,32'h1000}, // R9
    '{4'd9, 1,1,12'h341,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h400,     0,32'h0},    // R9
    '{4'd5, 1,1,12'h341,2'd1,0,32'h503,     0,32'h0,   0,0, 1,32'h400,     0,32'h0},    // R5
    '{4'd5, 1,1,12'h341,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h500,     0,32'h0},    // R5
    '{4'd11,1,1,12'h7C0,2'd1,0,32'hFFFF,    0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R11
    '{4'd11,1,1,12'h7C0,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h0,       0,32'h0},    // R11
    '{4'd11,0,1,12'h305,2'd1,0,32'h0,       0,32'h0,   0,0, 0,32'h0,       0,32'h0},    // R11
    '{4'd11,1,1,12'h305,2'd2,1,32'h0,       0,32'h0,   0,0, 1,32'h1000,    0,32'h0}     // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    retire_i = 0; csr_en_i = 0; csr_addr_i = '0; csr_op_i = '0;
    csr_src_zero_i = 0; csr_wdata_i = '0; mret_i = 0; pc_i = '0;
    irq_timer_i = 0; irq_soft_i = 0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    retire_i = v.ret; csr_en_i = v.en; csr_addr_i = v.addr; csr_op_i = v.op;
    csr_src_zero_i = v.z; csr_wdata_i = v.wd; mret_i = v.mr; pc_i = v.pc;
    irq_timer_i = v.tmr; irq_soft_i = v.sw;
    @(posedge clk);
    #1 idle();
    @(negedge clk);
  endtask

  task automatic read_reg(input logic [11:0] a);
    vec_t v;
    v = '0;
    v.ret = 1; v.en = 1; v.addr = a; v.op = 2'd2; v.z = 1;
    apply(v);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1 rdata after reset", csr_rdata_o, 32'h0);
    check("R1 redirect after reset", {31'h0, redirect_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      if (TBL[i].chk_rd)
        check($sformatf("R%0d vec%0d rdata", TBL[i].req, i), csr_rdata_o, TBL[i].exp_rd);
      check($sformatf("R%0d vec%0d redirect", TBL[i].req, i), {31'h0, redirect_o},
            {31'h0, TBL[i].exp_rv});
      if (TBL[i].exp_rv)
        check($sformatf("R%0d vec%0d target", TBL[i].req, i), redirect_pc_o, TBL[i].exp_rpc);
    end

    // R1: reset in mid-run returns every register to zero
    @(negedge clk) rst = 1;
    @(posedge clk);
    #1 rst = 0;
    read_reg(12'h305);
    check("R1 vector after mid-run reset", csr_rdata_o, 32'h0);
    read_reg(12'h300);
    check("R1 status after mid-run reset", csr_rdata_o, 32'h0);
    read_reg(12'h341);
    check("R1 return address after mid-run reset", csr_rdata_o, 32'h0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule